// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Typed Invalidation

This block is a small, fully associative cache of address translations. Each slot holds one leaf entry word together with the context number that owned the mapping, the virtual page tag and the size of the mapped area. There are three sizes: a 4 KB page, a 256 KB segment or a 16 MB region. A lookup port takes a virtual address. In the same cycle it reports whether a slot in the current context covers that address, and if so it returns the stored word and its physical page field.

A single command port carries two kinds of operation. A command write is an invalidation, and a 3-bit kind field inside the command address selects its scope: one page, one segment, one region, every mapping of the current context, or the whole cache. A command read of kind 4 is a probe that returns the cached word for a page address, or zero. New entries come from an external table walker through a separate refill port. Slots are reused in round-robin order, except when the refilled mapping is already cached, in which case its slot is rewritten.

Top module: `ctx_tlb`

## Requirements
- R1: After reset no slot is valid: every lookup misses with `lk_pte` and `lk_ppn` zero, and every probe returns zero.
- R2: A lookup hits when a valid slot's context equals `cur_ctx` and its tag equals the lookup address on bits [31:12] (page), [31:18] (segment) or [31:24] (region). On a hit `lk_pte` is the stored word and `lk_ppn` is its bits [31:8]. On a miss, or when `lk_valid` is low, the hit flag and both data outputs are zero.
- R3: A refill is written at the clock edge and can be looked up from the next cycle on. It is tagged with `cur_ctx` and `fill_va[31:12]`. `fill_lvl` encodes 0 = page, 1 = segment, 2 = region, and code 3 is treated as page.
- R4: A refill whose context, level and tag (under that level's bits) equal a slot that was valid before any invalidation in the same cycle rewrites that slot. Otherwise it goes to the round-robin slot, which starts at slot 0 after reset and moves on by one (wrapping) for each such allocation only.
- R5: A command write of kind 0 (`cmd_addr[10:8]`) removes each current-context slot whose mapped area overlaps the 4 KB page at `cmd_addr[31:12]`.
- R6: Kind 1 removes current-context slots that overlap the 256 KB segment at `cmd_addr[31:18]`, and kind 2 removes those that overlap the 16 MB region at `cmd_addr[31:24]`. Two areas overlap when their addresses agree on the bits that both sizes compare.
- R7: Kind 3 removes every slot of the current context, and kind 4 removes every slot. Kinds 5 to 7 change nothing. Kinds 0 to 3 never remove a slot of another context.
- R8: A lookup in the same cycle as an invalidation sees the state after the invalidation. A refill in the same cycle as an invalidation is kept.
- R9: A command read of kind 4 returns on `probe_data`, in the same cycle, the word of the current-context slot covering `cmd_addr`, with bits [11:0] ignored, or zero on a miss. `probe_data` is zero for reads of other kinds and for cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ctx | input | CTX_W | Current context number |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 32 | Leaf entry word of the hit slot |
| lk_ppn | output | 24 | Physical page field of the hit word |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = invalidation, 0 = read |
| cmd_addr | input | 32 | Command address with the kind in bits [10:8] |
| probe_data | output | 32 | Probe result |
| fill_valid | input | 1 | Refill strobe |
| fill_va | input | 32 | Refill virtual address |
| fill_lvl | input | 2 | Refill mapping size |
| fill_pte | input | 32 | Refill leaf entry word |

## Verification
The hardest case to reach from the ports is an invalidation whose scope and a slot's mapping size differ. A page invalidation must still remove a region slot that contains the page, and a region invalidation must remove a segment slot inside it. The slot must also be removed only in its own context. To get there, the bench reloads a fixed mix of page, segment and region slots across two contexts before every command. It then issues each of the eight kinds at three addresses, chosen to fall inside, beside and far from those slots, under two current contexts. After each command it sweeps lookups over boundary addresses in four contexts.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;

   localparam int unsigned VA_W     = 32;
   localparam int unsigned TAG_LSB  = 12;
   localparam int unsigned TAG_W    = VA_W - TAG_LSB;
   localparam int unsigned SEG_LSB  = 18;
   localparam int unsigned REG_LSB  = 24;
   localparam int unsigned PPN_LSB  = 8;
   localparam int unsigned KIND_LSB = 8;
   localparam int unsigned KIND_W   = 3;

   typedef logic [TAG_W-1:0] tag_t;

   typedef enum logic [1:0] {
      LVL_PAGE   = 2'd0,
      LVL_SEG    = 2'd1,
      LVL_REGION = 2'd2,
      LVL_RSVD   = 2'd3
   } lvl_e;

   typedef enum logic [KIND_W-1:0] {
      K_PAGE   = 3'd0,
      K_SEG    = 3'd1,
      K_REGION = 3'd2,
      K_CTX    = 3'd3,
      K_ALL    = 3'd4,
      K_NOP5   = 3'd5,
      K_NOP6   = 3'd6,
      K_NOP7   = 3'd7
   } kind_e;

   // Tag bits that an area of the given size compares.
   function automatic tag_t span_mask(input lvl_e l);
      tag_t m;
      m = '1;
      if (l == LVL_SEG)
         m = m << (SEG_LSB - TAG_LSB);
      else if (l == LVL_REGION)
         m = m << (REG_LSB - TAG_LSB);
      return m;
   endfunction

   function automatic lvl_e norm_lvl(input logic [1:0] raw);
      return (raw == 2'd3) ? LVL_PAGE : lvl_e'(raw);
   endfunction

endpackage

// File: rtl/ctx_tlb_cmd_dec.sv
module ctx_tlb_cmd_dec
   import ctx_tlb_pkg::*;
(
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [KIND_W-1:0] cmd_kind,
   output logic              fl_scoped,
   output logic              fl_all,
   output tag_t              fl_mask,
   output logic              probe_en
);

   kind_e kind;
   assign kind = kind_e'(cmd_kind);

   always_comb begin
      fl_scoped = 1'b0;
      fl_all    = 1'b0;
      fl_mask   = '1;
      if (cmd_valid && cmd_write) begin
         case (kind)
            K_PAGE: begin
               fl_scoped = 1'b1;
               fl_mask   = span_mask(LVL_PAGE);
            end
            K_SEG: begin
               fl_scoped = 1'b1;
               fl_mask   = span_mask(LVL_SEG);
            end
            K_REGION: begin
               fl_scoped = 1'b1;
               fl_mask   = span_mask(LVL_REGION);
            end
            K_CTX: begin
               fl_scoped = 1'b1;
               fl_mask   = '0;
            end
            K_ALL:   fl_all = 1'b1;
            default: ;
         endcase
      end
   end

   assign probe_en = cmd_valid && !cmd_write && (kind == K_ALL);

endmodule

// File: rtl/ctx_tlb_entry.sv
module ctx_tlb_entry
   import ctx_tlb_pkg::*;
#(
   parameter int unsigned CTX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CTX_W-1:0]  cur_ctx,
   input  tag_t              wr_tag,
   input  lvl_e              wr_lvl,
   input  logic [VA_W-1:0]   wr_pte,
   input  tag_t              lk_tag,
   input  tag_t              cmd_tag,
   input  tag_t              fl_mask,
   input  logic              fl_scoped,
   input  logic              fl_all,
   output logic              lk_match,
   output logic              pr_match,
   output logic              same,
   output logic [VA_W-1:0]   pte_q
);

   logic             vld_q;
   logic [CTX_W-1:0] ctx_q;
   tag_t             tag_q;
   lvl_e             lvl_q;

   tag_t emask;
   logic ctx_eq;
   logic fl_hit;

   assign emask  = span_mask(lvl_q);
   assign ctx_eq = (ctx_q == cur_ctx);

   // Overlap: equal on the bits both the command scope and the slot size compare.
   assign fl_hit = vld_q & (fl_all |
                   (fl_scoped & ctx_eq & (((cmd_tag ^ tag_q) & fl_mask & emask) == '0)));

   assign lk_match = vld_q & ~fl_hit & ctx_eq & (((lk_tag ^ tag_q) & emask) == '0);
   assign pr_match = vld_q & ctx_eq & (((cmd_tag ^ tag_q) & emask) == '0);
   assign same     = vld_q & ctx_eq & (lvl_q == wr_lvl) & (((wr_tag ^ tag_q) & emask) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         ctx_q <= '0;
         tag_q <= '0;
         lvl_q <= LVL_PAGE;
         pte_q <= '0;
      end else if (we) begin
         vld_q <= 1'b1;
         ctx_q <= cur_ctx;
         tag_q <= wr_tag;
         lvl_q <= wr_lvl;
         pte_q <= wr_pte;
      end else if (fl_hit) begin
         vld_q <= 1'b0;
      end
   end

endmodule

// File: rtl/ctx_tlb_rr.sv
module ctx_tlb_rr #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [IDX_W-1:0] idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)   idx <= '0;
            else if (adv) idx <= idx + 1'b1;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)   idx <= '0;
            else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
   import ctx_tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned CTX_W   = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CTX_W-1:0]   cur_ctx,
   input  logic               lk_valid,
   input  logic [31:0]        lk_va,
   output logic               lk_hit,
   output logic [31:0]        lk_pte,
   output logic [23:0]        lk_ppn,
   input  logic               cmd_valid,
   input  logic               cmd_write,
   input  logic [31:0]        cmd_addr,
   output logic [31:0]        probe_data,
   input  logic               fill_valid,
   input  logic [31:0]        fill_va,
   input  logic [1:0]         fill_lvl,
   input  logic [31:0]        fill_pte
);

   localparam int unsigned IDX_W = $clog2(ENTRIES);

   generate
      if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
         $error("ctx_tlb: ENTRIES must lie in 2..64");
      end
      if (CTX_W < 1 || CTX_W > 16) begin : g_bad_ctx
         $error("ctx_tlb: CTX_W must lie in 1..16");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{lk_va[TAG_LSB-1:0], fill_va[TAG_LSB-1:0],
                          cmd_addr[TAG_LSB-1], cmd_addr[KIND_LSB-1:0]};

   tag_t lk_tag, cmd_tag, fill_tag, fl_mask;
   lvl_e fill_lvl_n;
   logic fl_scoped, fl_all, probe_en;

   assign lk_tag     = lk_va[VA_W-1:TAG_LSB];
   assign cmd_tag    = cmd_addr[VA_W-1:TAG_LSB];
   assign fill_tag   = fill_va[VA_W-1:TAG_LSB];
   assign fill_lvl_n = norm_lvl(fill_lvl);

   ctx_tlb_cmd_dec u_dec (
      .cmd_valid (cmd_valid),
      .cmd_write (cmd_write),
      .cmd_kind  (cmd_addr[KIND_LSB+KIND_W-1:KIND_LSB]),
      .fl_scoped (fl_scoped),
      .fl_all    (fl_all),
      .fl_mask   (fl_mask),
      .probe_en  (probe_en)
   );

   logic [ENTRIES-1:0] lk_m, pr_m, same_v, we_v;
   logic [VA_W-1:0]    pte_a [ENTRIES];
   logic               any_same;
   logic [IDX_W-1:0]   rr_idx;

   assign any_same = |same_v;

   ctx_tlb_rr #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_rr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (fill_valid & ~any_same),
      .idx   (rr_idx)
   );

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         assign we_v[g] = fill_valid & (any_same ? same_v[g] : (rr_idx == IDX_W'(g)));

         ctx_tlb_entry #(.CTX_W(CTX_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (we_v[g]),
            .cur_ctx   (cur_ctx),
            .wr_tag    (fill_tag),
            .wr_lvl    (fill_lvl_n),
            .wr_pte    (fill_pte),
            .lk_tag    (lk_tag),
            .cmd_tag   (cmd_tag),
            .fl_mask   (fl_mask),
            .fl_scoped (fl_scoped),
            .fl_all    (fl_all),
            .lk_match  (lk_m[g]),
            .pr_match  (pr_m[g]),
            .same      (same_v[g]),
            .pte_q     (pte_a[g])
         );
      end
   endgenerate

   logic [VA_W-1:0] lk_or, pr_or;

   always_comb begin
      lk_or = '0;
      pr_or = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (lk_m[i]) lk_or = lk_or | pte_a[i];
         if (pr_m[i]) pr_or = pr_or | pte_a[i];
      end
   end

   assign lk_hit     = lk_valid & (|lk_m);
   assign lk_pte     = lk_hit ? lk_or : '0;
   assign lk_ppn     = lk_pte[VA_W-1:PPN_LSB];
   assign probe_data = probe_en ? pr_or : '0;

endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
   parameter int unsigned CTX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CTX_W-1:0] cur_ctx,
   input logic             lk_valid,
   input logic [19:0]      lk_tag,
   input logic             lk_hit,
   input logic [31:0]      lk_pte,
   input logic             cmd_valid,
   input logic             cmd_write,
   input logic [2:0]       cmd_kind,
   input logic [31:0]      probe_data,
   input logic             fill_valid,
   input logic [19:0]      fill_tag
);

   p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !lk_hit);

   p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_pte == 32'd0));

   p_fill_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fill_valid) && lk_valid && !(cmd_valid && cmd_write)
       && (lk_tag == $past(fill_tag)) && (cur_ctx == $past(cur_ctx))) |-> lk_hit);

   p_flush_all_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && cmd_kind == 3'd4 && !fill_valid) |=> !lk_hit);

   p_flush_all_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_write && cmd_kind == 3'd4) |-> !lk_hit);

   p_probe_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && !cmd_write && cmd_kind == 3'd4) |-> (probe_data == 32'd0));

endmodule

bind ctx_tlb ctx_tlb_chk #(.CTX_W(CTX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cur_ctx    (cur_ctx),
   .lk_valid   (lk_valid),
   .lk_tag     (lk_va[31:12]),
   .lk_hit     (lk_hit),
   .lk_pte     (lk_pte),
   .cmd_valid  (cmd_valid),
   .cmd_write  (cmd_write),
   .cmd_kind   (cmd_addr[10:8]),
   .probe_data (probe_data),
   .fill_valid (fill_valid),
   .fill_tag   (fill_va[31:12])
);

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;

   localparam int N  = 4;
   localparam int CW = 4;
   localparam int NA = 15;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [CW-1:0] cur_ctx;
   logic          lk_valid;
   logic [31:0]   lk_va;
   logic          lk_hit;
   logic [31:0]   lk_pte;
   logic [23:0]   lk_ppn;
   logic          cmd_valid;
   logic          cmd_write;
   logic [31:0]   cmd_addr;
   logic [31:0]   probe_data;
   logic          fill_valid;
   logic [31:0]   fill_va;
   logic [1:0]    fill_lvl;
   logic [31:0]   fill_pte;

   always #10 clk = ~clk;

   ctx_tlb #(.ENTRIES(N), .CTX_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .cur_ctx(cur_ctx),
      .lk_valid(lk_valid), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pte(lk_pte), .lk_ppn(lk_ppn),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .probe_data(probe_data),
      .fill_valid(fill_valid), .fill_va(fill_va), .fill_lvl(fill_lvl), .fill_pte(fill_pte)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // Reference state kept from the requirements.
   bit          mv   [N];
   logic [3:0]  mctx [N];
   logic [19:0] mtag [N];
   int          mlvl [N];
   logic [31:0] mpte [N];
   int          mptr;

   logic [31:0] addrs [NA];

   function automatic logic [19:0] span(int l);
      if (l == 1) return 20'hFFFC0;
      if (l == 2) return 20'hFF000;
      return 20'hFFFFF;
   endfunction

   function automatic bit covers(int i, logic [19:0] t, logic [3:0] c);
      return mv[i] && (mctx[i] == c) && (((t ^ mtag[i]) & span(mlvl[i])) == 20'd0);
   endfunction

   function automatic bit killed(int i);
      int k;
      if (!(cmd_valid && cmd_write) || !mv[i]) return 0;
      k = int'(cmd_addr[10:8]);
      if (k == 4) return 1;
      if (k > 4 || mctx[i] != cur_ctx) return 0;
      if (k == 3) return 1;
      return ((cmd_addr[31:12] ^ mtag[i]) & span(k) & span(mlvl[i])) == 20'd0;
   endfunction

   task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
      end
   endtask

   task automatic cyc(string r);
      bit          eh;
      logic [31:0] ep, epr;
      bit          kv [N];
      bit          sv [N];
      bit          anys;
      int          nl;
      #5;
      if (lk_valid) begin
         eh = 0; ep = '0;
         for (int i = 0; i < N; i++)
            if (covers(i, lk_va[31:12], cur_ctx) && !killed(i)) begin
               eh = 1; ep = ep | mpte[i];
            end
         chk(r, "lk_hit", {31'd0, lk_hit}, {31'd0, eh});
         chk(r, "lk_pte", lk_pte, ep);
         chk(r, "lk_ppn", {8'd0, lk_ppn}, {8'd0, ep[31:8]});
      end
      epr = '0;
      if (cmd_valid && !cmd_write && cmd_addr[10:8] == 3'd4)
         for (int i = 0; i < N; i++)
            if (covers(i, cmd_addr[31:12], cur_ctx)) epr = epr | mpte[i];
      chk(r, "probe_data", probe_data, epr);
      // next state
      for (int i = 0; i < N; i++) kv[i] = killed(i);
      nl = (fill_lvl == 2'd3) ? 0 : int'(fill_lvl);
      anys = 0;
      for (int i = 0; i < N; i++) begin
         sv[i] = mv[i] && (mctx[i] == cur_ctx) && (mlvl[i] == nl) &&
                 (((fill_va[31:12] ^ mtag[i]) & span(mlvl[i])) == 20'd0);
         anys |= sv[i];
      end
      for (int i = 0; i < N; i++) if (kv[i]) mv[i] = 0;
      if (fill_valid) begin
         for (int i = 0; i < N; i++) begin
            if ((anys && sv[i]) || (!anys && i == mptr)) begin
               mv[i] = 1; mctx[i] = cur_ctx; mtag[i] = fill_va[31:12];
               mlvl[i] = nl; mpte[i] = fill_pte;
            end
         end
         if (!anys) mptr = (mptr + 1) % N;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      lk_valid = 0; lk_va = '0;
      cmd_valid = 0; cmd_write = 0; cmd_addr = '0;
      fill_valid = 0; fill_va = '0; fill_lvl = '0; fill_pte = '0;
   endtask

   task automatic do_fill(int c, logic [31:0] va, int l, logic [31:0] pte, string r);
      idle();
      cur_ctx = c[3:0]; fill_valid = 1; fill_va = va; fill_lvl = l[1:0]; fill_pte = pte;
      cyc(r);
   endtask

   task automatic do_flush(int c, int k, logic [31:0] a, string r);
      idle();
      cur_ctx = c[3:0]; cmd_valid = 1; cmd_write = 1;
      cmd_addr = {a[31:11], k[2:0], a[7:0]};
      cyc(r);
   endtask

   task automatic sweep(string r);
      for (int i = 0; i < NA; i++)
         for (int c = 0; c < 4; c++) begin
            idle();
            cur_ctx = c[3:0]; lk_valid = 1; lk_va = addrs[i] | 32'h0000_0ABC;
            cyc(r);
         end
   endtask

   task automatic psweep(string r);
      for (int i = 0; i < NA; i++)
         for (int c = 0; c < 4; c++) begin
            idle();
            cur_ctx = c[3:0]; cmd_valid = 1;
            cmd_addr = {addrs[i][31:12], 1'b1, 3'd4, 8'h5A};
            cyc(r);
            idle();
            cur_ctx = c[3:0]; cmd_valid = 1;
            cmd_addr = {addrs[i][31:12], 1'b0, 3'd0, 8'h00};
            cyc(r);
         end
   endtask

   task automatic load();
      do_fill(1, 32'h0040_3000, 0, 32'hA5A5_11AE, "R3");
      do_fill(1, 32'h0080_0000, 1, 32'h1234_56CE, "R3");
      do_fill(1, 32'h0300_0000, 2, 32'h0FED_C0BE, "R3");
      do_fill(2, 32'h0040_3000, 0, 32'h7777_70AE, "R3");
   endtask

   function automatic string ktag(int k);
      if (k == 0) return "R5";
      if (k <= 2) return "R6";
      return "R7";
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired before the run completed");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] fa [3];
      addrs[0]  = 32'h0040_3000; addrs[1]  = 32'h0040_2000; addrs[2]  = 32'h0040_4000;
      addrs[3]  = 32'h0080_0000; addrs[4]  = 32'h0083_F000; addrs[5]  = 32'h0084_0000;
      addrs[6]  = 32'h007F_F000; addrs[7]  = 32'h0300_0000; addrs[8]  = 32'h03FF_F000;
      addrs[9]  = 32'h0400_0000; addrs[10] = 32'h02FF_F000; addrs[11] = 32'h0500_0000;
      addrs[12] = 32'h0600_0000; addrs[13] = 32'h0600_1000; addrs[14] = 32'h0700_0000;
      fa[0] = 32'h0040_3000; fa[1] = 32'h0083_F000; fa[2] = 32'h03A0_0000;
      for (int i = 0; i < N; i++) begin
         mv[i] = 0; mctx[i] = '0; mtag[i] = '0; mlvl[i] = 0; mpte[i] = '0;
      end
      mptr = 0;
      idle(); cur_ctx = '0; rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      sweep("R1");
      psweep("R1");

      load();
      sweep("R2");
      psweep("R9");

      // in-place rewrite, then allocation evicts slot 0
      do_fill(1, 32'h0040_3000, 0, 32'h5555_50AE, "R4");
      sweep("R4");
      do_fill(1, 32'h0500_0000, 0, 32'h3333_30AE, "R4");
      sweep("R4");
      do_fill(2, 32'h0600_0000, 3, 32'h4444_40AE, "R3");
      sweep("R3");

      for (int k = 0; k < 8; k++)
         for (int a = 0; a < 3; a++)
            for (int c = 1; c < 3; c++) begin
               load();
               do_flush(c, k, fa[a], ktag(k));
               sweep(ktag(k));
            end

      // same-cycle lookup and refill against a full invalidation
      load();
      idle();
      cur_ctx = 4'd1; cmd_valid = 1; cmd_write = 1; cmd_addr = 32'h0000_0400;
      lk_valid = 1; lk_va = 32'h0083_F000;
      fill_valid = 1; fill_va = 32'h0700_0000; fill_lvl = 2'd0; fill_pte = 32'h9999_90AE;
      cyc("R8");
      sweep("R8");
      // same-cycle lookup against a segment invalidation
      load();
      idle();
      cur_ctx = 4'd1; cmd_valid = 1; cmd_write = 1; cmd_addr = 32'h0083_F100;
      lk_valid = 1; lk_va = 32'h0081_0000;
      cyc("R8");
      sweep("R8");

      idle();
      done = 1;
      summary();
      $finish;
   end

endmodule